// File: doc/BRIEF.md
# Sub-band Serial Sample Delay Line

This block sits between a sub-band filter and a codec on a framed serial sample link. Each word-select period carries one left and one right 24-bit sample. The block deserialises both samples from the data pin that is currently the input and stores them in a circular buffer. A fixed number of word-select periods later it sends them out again on the opposite data pin, in the same serial format. The length of the delay is set by the operating direction: 480 periods in encode mode and 160 periods in decode mode.

The direction is taken from `dir_i` at the moment a frame-reset pulse ends. It decides which data pin is the input and which is the output. Each data pin has its own output enable, so the pads can be built as tri-state buffers. A newly selected output stays disabled for a short guard time after the pulse ends. The frame-sync input marks the sub-band 0 period. The buffer starts storing from the first such period, so the delayed stream stays in step with the 32-period sub-band cycle.

All inputs are synchronous to the system clock `clk_i`. Rising edges of the bit clock are detected in that clock domain.

Top module: `subband_delay_line`

## Requirements
- R1: After `rst_ni` is released, `filt_oe_o` and `cdc_oe_o` stay low until the first frame-reset pulse on `frame_rst_i` has ended.
- R2: `dir_i` is sampled only on the first clock edge at which `frame_rst_i` is seen low after being high. Value 0 selects encode mode: input on `filt_d_i`, output on `cdc_d_o`. Value 1 selects decode mode: input on `cdc_d_i`, output on `filt_d_o`. Changes to `dir_i` at any other time have no effect.
- R3: After that edge, the output enable of the selected pin rises exactly 4 clock edges later, so it is low for at least 3 cycles. The output enable of the other pin stays low, and the two enables are never high together.
- R4: While `frame_rst_i` is high, both output enables go low from the first clock edge that sees it, and both data outputs read 0.
- R5: A bit-clock rising edge at which `sws_i` differs from its value at the previous rising edge is slot 0 of a half period. Slots 1 to 24 carry the sample, most significant bit first. `sws_i` low means left and high means right. Slot 0 of a left half starts a new period.
- R6: Output bits change on the clock edge that detects a bit-clock rise. The bit for slot k is driven after the rise of slot k-1. Slots 0 and 25 to 31 of each half are driven low.
- R7: In encode mode, the left and right samples received in period p are sent in period p+480.
- R8: In decode mode, the samples received in period p are sent in period p+160.
- R9: Storage starts with the first period whose slot-0 rise sees `fsync_i` high, and that period is the first one stored. Until its delayed copy is due, the output carries all-zero samples. Later `fsync_i` pulses do not shift the alignment.
- R10: The data input of the pin that is not selected has no effect on the output stream.
- R11: A new frame-reset pulse discards stored samples, so the output is all-zero again until the new delay has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_rst_i | input | 1 | Frame-reset pulse, active high; its end latches the direction |
| dir_i | input | 1 | Direction request: 0 encode, 1 decode |
| scl_i | input | 1 | Serial bit clock, 64 per period |
| sws_i | input | 1 | Word select: low left, high right |
| fsync_i | input | 1 | Marks the sub-band 0 period |
| filt_d_i | input | 1 | Filter-side data in (encode input) |
| filt_d_o | output | 1 | Filter-side data out (decode output) |
| filt_oe_o | output | 1 | Filter-side output enable |
| cdc_d_i | input | 1 | Codec-side data in (decode input) |
| cdc_d_o | output | 1 | Codec-side data out (encode output) |
| cdc_oe_o | output | 1 | Codec-side output enable |

## Verification
The hardest case to reach is the exact edge of the delay window. The period 479 (or 159) periods after the first frame-sync period must still be zero, and the next one must carry that first stored period. Reaching that edge means running a continuous stream for the full buffer length, so the bench drives 489 unbroken periods in encode mode with frame sync repeating every 32 periods. The unselected pin carries the inverted pattern throughout. A decode run follows directly, without a new power-on reset, which shows that the earlier contents were discarded and that the shorter delay applies.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef enum logic {DIR_ENC = 1'b0, DIR_DEC = 1'b1} dir_e;
endpackage

// File: rtl/sbd_ctrl.sv
module sbd_ctrl
  import sbd_pkg::*;
#(
  parameter int GUARD_CYC = 3,
  localparam int GW = $clog2(GUARD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_rst_i,
  input  logic dir_i,
  output dir_e dir_o,
  output logic run_o,
  output logic oe_o
);
  logic          fr_q;
  logic [GW-1:0] guard_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q    <= 1'b0;
      dir_o   <= DIR_DEC;
      run_o   <= 1'b0;
      guard_q <= GW'(GUARD_CYC);
      oe_o    <= 1'b0;
    end else begin
      fr_q <= frame_rst_i;
      if (frame_rst_i) begin
        run_o   <= 1'b0;
        oe_o    <= 1'b0;
        guard_q <= GW'(GUARD_CYC);
      end else if (fr_q) begin
        // end of pulse: latch direction, start guard window
        dir_o   <= dir_e'(dir_i);
        run_o   <= 1'b1;
        guard_q <= GW'(GUARD_CYC);
        oe_o    <= 1'b0;
      end else begin
        if (guard_q != '0) guard_q <= guard_q - 1'b1;
        oe_o <= run_o && (guard_q == '0);
      end
    end
  end

  a_r4_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rst_i |=> !oe_o);
  a_r3_oe_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> (!$past(frame_rst_i, 1) && !$past(frame_rst_i, 2) &&
                     !$past(frame_rst_i, 3) && !$past(frame_rst_i, 4)));
  a_r2_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(dir_o));
  a_r1_no_oe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |=> !oe_o);
endmodule

// File: rtl/sbd_deser.sv
module sbd_deser #(
  parameter int W      = 24,
  parameter int SLOT_N = 32,
  localparam int CW    = $clog2(SLOT_N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           scl_i,
  input  logic           sws_i,
  input  logic           sd_i,
  output logic           rise_o,
  output logic [CW-1:0]  cnt_o,
  output logic           half_o,
  output logic           bound_o,
  output logic [2*W-1:0] samp_o
);
  logic          scl_q, sws_q, new_half;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q [2];

  assign rise_o   = scl_i & ~scl_q;
  assign new_half = rise_o & (sws_i != sws_q);
  assign cnt_o    = new_half ? '0 : cnt_q + 1'b1;
  assign half_o   = sws_i;
  assign bound_o  = new_half & ~sws_i;
  assign samp_o   = {sh_q[0], sh_q[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b0;
    else         scl_q <= scl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sws_q <= 1'b1;
      cnt_q <= '0;
    end else if (clr_i) begin
      sws_q <= 1'b1;
      cnt_q <= '0;
    end else if (rise_o) begin
      sws_q <= sws_i;
      cnt_q <= cnt_o;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q[ch] <= '0;
      else if (clr_i)   sh_q[ch] <= '0;
      else if (rise_o && (sws_i == 1'(ch)) && (cnt_o != '0) && (cnt_o <= CW'(W)))
        sh_q[ch] <= {sh_q[ch][W-2:0], sd_i};
    end
  end

  a_r5_bound_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_o |-> (rise_o && !half_o));
endmodule

// File: rtl/sbd_delay_mem.sv
module sbd_delay_mem
  import sbd_pkg::*;
#(
  parameter int W2      = 48,
  parameter int DLY_ENC = 480,
  parameter int DLY_DEC = 160,
  localparam int DEPTH  = (DLY_ENC > DLY_DEC) ? DLY_ENC : DLY_DEC,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  dir_e          dir_i,
  input  logic          step_i,
  input  logic          arm_i,
  input  logic [W2-1:0] wdata_i,
  output logic [W2-1:0] rd_word_o
);
  localparam int OFS_ENC = DEPTH - DLY_ENC + 1;
  localparam int OFS_DEC = DEPTH - DLY_DEC + 1;

  logic [W2-1:0] mem_q [DEPTH];
  logic [AW-1:0] ptr_q, rd_idx;
  logic [AW:0]   fill_q, sum;
  logic          armed_q, rd_ok;
  int            dly;

  assign dly    = (dir_i == DIR_ENC) ? DLY_ENC : DLY_DEC;
  assign sum    = {1'b0, ptr_q} + ((dir_i == DIR_ENC) ? (AW+1)'(OFS_ENC) : (AW+1)'(OFS_DEC));
  assign rd_idx = (sum >= (AW+1)'(DEPTH)) ? AW'(sum - (AW+1)'(DEPTH)) : AW'(sum);
  // entry is live once this step's write brings the fill up to the delay
  assign rd_ok  = armed_q && ((int'(fill_q) + 1) >= dly);
  assign rd_word_o = rd_ok ? mem_q[rd_idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q   <= '0;
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else if (step_i) begin
      if (armed_q) begin
        ptr_q <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        if (fill_q != (AW+1)'(DEPTH)) fill_q <= fill_q + 1'b1;
      end
      if (arm_i) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (step_i && armed_q && !clr_i) mem_q[ptr_q] <= wdata_i;
  end

  a_r9_unarmed_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (rd_word_o == '0));
  a_r7_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= (AW+1)'(DEPTH));
  a_r11_clear_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fill_q == '0 && !armed_q));
endmodule

// File: rtl/sbd_ser.sv
module sbd_ser #(
  parameter int W      = 24,
  parameter int SLOT_N = 32,
  localparam int CW    = $clog2(SLOT_N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           rise_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic           half_i,
  input  logic           bound_i,
  input  logic [2*W-1:0] word_i,
  output logic           sd_o
);
  logic [2*W-1:0] word_q, cur;
  logic [W-1:0]   sel;
  logic [CW-1:0]  bidx;

  assign cur  = bound_i ? word_i : word_q;
  assign sel  = half_i ? cur[W-1:0] : cur[2*W-1:W];
  assign bidx = CW'(W - 1) - cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sd_o   <= 1'b0;
    end else if (clr_i) begin
      word_q <= '0;
      sd_o   <= 1'b0;
    end else if (rise_i) begin
      if (bound_i) word_q <= word_i;
      // drive the bit for the next slot
      sd_o <= (cnt_i < CW'(W)) ? sel[bidx] : 1'b0;
    end
  end

  a_r6_idle_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !clr_i && cnt_i >= CW'(W)) |=> !sd_o);
endmodule

// File: rtl/subband_delay_line.sv
module subband_delay_line
  import sbd_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_N    = 32,
  parameter int DLY_ENC   = 480,
  parameter int DLY_DEC   = 160,
  parameter int GUARD_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_rst_i,
  input  logic dir_i,
  input  logic scl_i,
  input  logic sws_i,
  input  logic fsync_i,
  input  logic filt_d_i,
  output logic filt_d_o,
  output logic filt_oe_o,
  input  logic cdc_d_i,
  output logic cdc_d_o,
  output logic cdc_oe_o
);
  localparam int CW = $clog2(SLOT_N);
  localparam int W2 = 2 * SAMPLE_W;

  dir_e          dir;
  logic          run, oe, clr, sd_in, sd_out;
  logic          rise, half, bound;
  logic [CW-1:0] cnt;
  logic [W2-1:0] samp, rd_word;

  assign clr   = ~run;
  assign sd_in = (dir == DIR_ENC) ? filt_d_i : cdc_d_i;

  sbd_ctrl #(.GUARD_CYC(GUARD_CYC)) u_ctrl (
    .clk_i, .rst_ni, .frame_rst_i, .dir_i,
    .dir_o(dir), .run_o(run), .oe_o(oe)
  );

  sbd_deser #(.W(SAMPLE_W), .SLOT_N(SLOT_N)) u_deser (
    .clk_i, .rst_ni, .clr_i(clr), .scl_i, .sws_i, .sd_i(sd_in),
    .rise_o(rise), .cnt_o(cnt), .half_o(half), .bound_o(bound), .samp_o(samp)
  );

  sbd_delay_mem #(.W2(W2), .DLY_ENC(DLY_ENC), .DLY_DEC(DLY_DEC)) u_mem (
    .clk_i, .rst_ni, .clr_i(clr), .dir_i(dir), .step_i(bound),
    .arm_i(bound & fsync_i), .wdata_i(samp), .rd_word_o(rd_word)
  );

  sbd_ser #(.W(SAMPLE_W), .SLOT_N(SLOT_N)) u_ser (
    .clk_i, .rst_ni, .clr_i(clr), .rise_i(rise), .cnt_i(cnt), .half_i(half),
    .bound_i(bound), .word_i(rd_word), .sd_o(sd_out)
  );

  assign filt_oe_o = oe & (dir == DIR_DEC);
  assign cdc_oe_o  = oe & (dir == DIR_ENC);
  assign filt_d_o  = filt_oe_o & sd_out;
  assign cdc_d_o   = cdc_oe_o & sd_out;

  a_r3_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(filt_oe_o && cdc_oe_o));
  a_r4_quiet_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rst_i |=> (!filt_d_o && !cdc_d_o));
endmodule

// File: tb/subband_delay_line_test.sv
module subband_delay_line_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_rst_i = 1'b0;
  logic dir_i = 1'b0;
  logic scl_i = 1'b0;
  logic sws_i = 1'b1;
  logic fsync_i = 1'b0;
  logic filt_d_i = 1'b0;
  logic cdc_d_i = 1'b0;
  logic filt_d_o, filt_oe_o, cdc_d_o, cdc_oe_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  subband_delay_line uut (
    .clk_i(clk), .rst_ni, .frame_rst_i, .dir_i, .scl_i, .sws_i, .fsync_i,
    .filt_d_i, .filt_d_o, .filt_oe_o, .cdc_d_i, .cdc_d_o, .cdc_oe_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] smp(input int p, input int h);
    if (h == 0) return 24'h5A0000 ^ 24'(p * 977);
    else        return 24'hA30001 ^ 24'(p * 331);
  endfunction

  // R1: idle after power-on reset
  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 oe after reset", {30'b0, filt_oe_o, cdc_oe_o}, 32'h0);
    check("R1 data after reset", {30'b0, filt_d_o, cdc_d_o}, 32'h0);
  endtask

  // R2 R3 R4: frame-reset pulse and guard window
  task automatic t_frame_reset(input bit dec);
    @(negedge clk);
    frame_rst_i = 1'b1;
    dir_i = dec;
    @(negedge clk);
    check("R4 oe low in frame reset", {30'b0, filt_oe_o, cdc_oe_o}, 32'h0);
    @(negedge clk);
    check("R4 data low in frame reset", {30'b0, filt_d_o, cdc_d_o}, 32'h0);
    frame_rst_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3 guard keeps oe low", {30'b0, filt_oe_o, cdc_oe_o}, 32'h0);
    end
    @(negedge clk);
    check("R2 R3 selected oe after guard", {30'b0, filt_oe_o, cdc_oe_o},
          dec ? 32'h2 : 32'h1);
    dir_i = ~dec; // R2: ignored until next pulse
  endtask

  // R5..R10: continuous stream, both pins driven, unselected one inverted
  task automatic t_stream(input bit dec, input int n_per, input int fs0, input int dly,
                          input string req);
    for (int p = 0; p < n_per; p++) begin
      for (int h = 0; h < 2; h++) begin
        logic [31:0] rx, ex;
        logic [23:0] s;
        rx = '0;
        s = smp(p, h);
        for (int sl = 0; sl < 32; sl++) begin
          logic b;
          b = (sl >= 1 && sl <= 24) ? s[24 - sl] : 1'b0;
          @(negedge clk);
          scl_i = 1'b0;
          sws_i = 1'(h);
          fsync_i = (p >= fs0) && (((p - fs0) % 32) == 0);
          if (dec) begin cdc_d_i = b; filt_d_i = ~b; end
          else     begin filt_d_i = b; cdc_d_i = ~b; end
          @(negedge clk);
          scl_i = 1'b1;
          rx[31 - sl] = dec ? filt_d_o : cdc_d_o;
        end
        ex = (p - dly >= fs0) ? {1'b0, smp(p - dly, h), 7'b0} : 32'h0;
        check(req, rx, ex);
      end
      check("R3 R10 oe during stream", {30'b0, filt_oe_o, cdc_oe_o}, dec ? 32'h2 : 32'h1);
    end
  endtask

  task automatic t_encode();
    t_frame_reset(1'b0);
    t_stream(1'b0, 489, 5, 480, "R5 R6 R7 R9 R10 encode stream");
  endtask

  // R11: follows encode with no power-on reset; old contents must not reappear
  task automatic t_decode();
    t_frame_reset(1'b1);
    t_stream(1'b1, 169, 3, 160, "R5 R6 R8 R9 R10 R11 decode stream");
  endtask

  task automatic t_hold_reset();
    @(negedge clk);
    frame_rst_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 held frame reset", {28'b0, filt_oe_o, cdc_oe_o, filt_d_o, cdc_d_o}, 32'h0);
    end
  endtask

  initial begin
    t_reset();
    t_encode();
    t_decode();
    t_hold_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule